// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets a host read and write a bank of 32 byte-wide configuration registers over a three-wire serial link. The link has a serial clock, an active-low select and one data line. In this implementation the data line is split into an input, an output and an output-enable, which a pad ring combines. Every exchange opens with an eight-bit command. The command carries the direction, a byte count of one to four and a starting register. The data bytes follow, and the register address moves by one after each byte.

Register 0 holds the port's own settings. Bit 6 selects the bit order. It also sets the direction of the address step: down in MSB-first mode and up in LSB-first mode. Bit 5 is a self-clearing software reset that restores every other register. A written byte lands in the bank on the rising edge that carries its last bit. A change to the bit order therefore applies to the rest of the same exchange. A separate port-reset input aborts whatever exchange is in progress. The serial pins are sampled with the fabric clock, so the serial clock must run several times slower than that clock.

Top module: `rsp_port`

## Requirements
- R1: The command byte is laid out as bit 7 = direction (1 read, 0 write), bits 6:5 = count code c, and bits 4:0 = first register. Exactly c+1 data bytes follow.
- R2: The data input is captured on serial-clock rising edges. The output changes only after falling edges. Each read byte's first bit is presented on the falling edge right after the previous byte's last rising edge.
- R3: The output enable is 0 whenever select is high or the command is a write. It is 1 during the data bytes of a read.
- R4: After reset the order is MSB first (register 0 bit 6 = 0). In that mode the address steps down by one after each data byte.
- R5: With register 0 bit 6 = 1, command and data bytes travel LSB first and the address steps up by one after each data byte.
- R6: When a write to register 0 changes bit 6, the new order governs both the bit order and the address step for every remaining byte of the same exchange.
- R7: A written register takes its new value as soon as the last bit of its byte is captured. Bytes clocked beyond the count are ignored.
- R8: Writing register 0 with bit 5 set returns registers 1 to 31 to their reset values. Register 0 keeps its other bits, and bit 5 reads back as 0.
- R9: A high pulse on the port-reset input discards a partly received byte and makes the next bit the first bit of a new command, even with select held low.
- R10: Raising select before a byte completes discards that byte. The next select assertion begins a new command.
- R11: The address stops at 0x00 when stepping down and at 0x1F when stepping up. Further bytes reuse the boundary register.
- R12: Synchronous reset sets register 0 to 0x00 and register k (k >= 1) to 0xA0 + k, and turns the output enable off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Active-low select that frames an exchange |
| prst_i | input | 1 | Port reset; a high pulse aborts the exchange |
| sdi_i | input | 1 | Serial data into the port |
| sdo_o | output | 1 | Serial read data out of the port |
| sdo_en_o | output | 1 | Drive enable for the shared data line |
| regs_o | output | 256 | Register bank, register k at bits 8k+7:8k |

## Verification
Two functions can fall on the same serial edge: the write of register 0 and the address step for the next byte. When that write flips the bit order, the step direction has to follow the new value and not the old one. The test provokes this with a two-byte MSB-first write that starts at register 0 and sets bit 6. The second byte is sent LSB first, and the test expects it in register 1, not in a saturated register 0. A software reset carried by the same write as a register-0 update is judged the same way: register 0 must keep its other bits while the rest of the bank reverts.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int ORDER_BIT = 6;
    localparam int SWRST_BIT = 5;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_IDLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        cnt;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic logic [DATA_W-1:0] reg_default(input int k);
        logic [DATA_W-1:0] v;
        v = (k == 0) ? '0 : (DATA_W'(8'hA0) | DATA_W'(k));
        return v;
    endfunction

endpackage

// File: rtl/rsp_regfile.sv
module rsp_regfile
    import rsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we_i,
    input  logic [AW-1:0]           waddr_i,
    input  logic [DW-1:0]           wdata_i,
    output logic [(1<<AW)*DW-1:0]   regs_o
);
    localparam int NREG = 1 << AW;
    localparam logic [DW-1:0] SW_MASK = DW'(1) << SWRST_BIT;

    logic [NREG-1:0][DW-1:0] bank_q;
    logic                    swrst;

    assign swrst = we_i && (waddr_i == '0) && wdata_i[SWRST_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) bank_q[k] <= reg_default(k);
        end else begin
            if (swrst) begin
                for (int k = 1; k < NREG; k++) bank_q[k] <= reg_default(k);
            end
            if (we_i) begin
                bank_q[waddr_i] <= (waddr_i == '0) ? (wdata_i & ~SW_MASK) : wdata_i;
            end
        end
    end

    assign regs_o = bank_q;

    // R8: software reset restores the bank and reads back as zero
    p_swrst_r8: assert property (@(posedge clk) disable iff (rst)
        (we_i && waddr_i == '0 && wdata_i[SWRST_BIT]) |=>
            (regs_o[DW +: DW] == reg_default(1)) && !regs_o[SWRST_BIT]);

endmodule

// File: rtl/rsp_shift.sv
module rsp_shift
    import rsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = $clog2(DATA_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          sdi_i,
    input  logic          lsb_i,
    input  logic [CW-1:0] bit_cnt_i,
    input  logic          load_i,
    input  logic [DW-1:0] tx_data_i,
    output logic [DW-1:0] rx_next_o,
    output logic          sdo_o
);
    logic [DW-1:0] rx_q;
    logic [DW-1:0] tx_q;
    logic          sdo_q;
    logic [CW-1:0] idx;

    assign rx_next_o = lsb_i ? {sdi_i, rx_q[DW-1:1]} : {rx_q[DW-2:0], sdi_i};
    assign idx       = lsb_i ? bit_cnt_i : (CW'(DW-1) - bit_cnt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q  <= '0;
            tx_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (rise_i) rx_q  <= rx_next_o;
            if (load_i) tx_q  <= tx_data_i;
            if (fall_i) sdo_q <= tx_q[idx];
        end
    end

    assign sdo_o = sdo_q;

    // R2: serial output only moves after a falling serial-clock edge
    p_sdo_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sdo_q)) |-> $past(fall_i));

endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
    import rsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = $clog2(DATA_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort_i,
    input  logic          rise_i,
    input  logic [DW-1:0] rx_next_i,
    input  logic          lsb_i,
    output phase_e        phase_o,
    output logic [CW-1:0] bit_cnt_o,
    output logic          rd_o,
    output logic          load_o,
    output logic [AW-1:0] nxt_addr_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [DW-1:0] wdata_o
);
    localparam logic [AW-1:0] ADDR_MAX = '1;

    phase_e        phase_q;
    logic [CW-1:0] bit_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    left_q;
    logic          rd_q;
    logic          last;
    logic          step_up;
    logic [AW-1:0] stepped;
    cmd_t          cmd;

    assign cmd  = cmd_t'(rx_next_i);
    assign last = rise_i && (bit_q == CW'(DW-1));

    assign we_o    = last && (phase_q == PH_DATA) && !rd_q;
    assign waddr_o = addr_q;
    assign wdata_o = rx_next_i;

    // a register-0 write steers the step with its own new order bit
    assign step_up = (we_o && addr_q == '0) ? rx_next_i[ORDER_BIT] : lsb_i;

    always_comb begin
        if (step_up) stepped = (addr_q == ADDR_MAX) ? addr_q : addr_q + AW'(1);
        else         stepped = (addr_q == '0)       ? addr_q : addr_q - AW'(1);
    end

    assign nxt_addr_o = (phase_q == PH_CMD) ? cmd.addr : stepped;
    assign load_o     = last && (((phase_q == PH_CMD) && cmd.rd) ||
                                 ((phase_q == PH_DATA) && rd_q && left_q != 2'd0));

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            phase_q <= PH_CMD;
            bit_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            rd_q    <= 1'b0;
        end else if (rise_i) begin
            bit_q <= bit_q + CW'(1);
            if (last) begin
                unique case (phase_q)
                    PH_CMD: begin
                        phase_q <= PH_DATA;
                        rd_q    <= cmd.rd;
                        left_q  <= cmd.cnt;
                        addr_q  <= cmd.addr;
                    end
                    PH_DATA: begin
                        addr_q <= stepped;
                        if (left_q == 2'd0) phase_q <= PH_IDLE;
                        else                left_q  <= left_q - 2'd1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase_o   = phase_q;
    assign bit_cnt_o = bit_q;
    assign rd_o      = rd_q;

    // R1: count code of the command sets the remaining byte budget
    p_count_r1: assert property (@(posedge clk) disable iff (rst)
        (last && phase_q == PH_CMD && !abort_i) |=> (left_q == $past(cmd.cnt)));

    // R9: an abort leaves the port at the first command bit
    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (phase_q == PH_CMD) && (bit_q == '0));

    // R11: address holds at the upper boundary
    p_sat_hi_r11: assert property (@(posedge clk) disable iff (rst)
        (last && !abort_i && phase_q == PH_DATA && addr_q == ADDR_MAX && step_up)
            |=> (addr_q == ADDR_MAX));

    // R11: address holds at the lower boundary
    p_sat_lo_r11: assert property (@(posedge clk) disable iff (rst)
        (last && !abort_i && phase_q == PH_DATA && addr_q == '0 && !step_up)
            |=> (addr_q == '0));

endmodule

// File: rtl/rsp_port.sv
module rsp_port
    import rsp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_i,
    input  logic                  csn_i,
    input  logic                  prst_i,
    input  logic                  sdi_i,
    output logic                  sdo_o,
    output logic                  sdo_en_o,
    output logic [(1<<AW)*DW-1:0] regs_o
);
    localparam int CW = $clog2(DW);

    logic          sclk_q;
    logic          rise, fall, abort;
    logic          lsb;
    phase_e        phase;
    logic [CW-1:0] bit_cnt;
    logic          rd, load, we;
    logic [AW-1:0] nxt_addr, waddr;
    logic [DW-1:0] wdata, rx_next, tx_data;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_i;
    end

    assign rise    = sclk_i && !sclk_q;
    assign fall    = !sclk_i && sclk_q;
    assign abort   = csn_i || prst_i;
    assign lsb     = regs_o[ORDER_BIT];
    assign tx_data = regs_o[nxt_addr*DW +: DW];

    rsp_seq #(.DW(DW), .AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .abort_i(abort), .rise_i(rise),
        .rx_next_i(rx_next), .lsb_i(lsb), .phase_o(phase),
        .bit_cnt_o(bit_cnt), .rd_o(rd), .load_o(load),
        .nxt_addr_o(nxt_addr), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
    );

    rsp_shift #(.DW(DW), .CW(CW)) u_shift (
        .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .sdi_i(sdi_i),
        .lsb_i(lsb), .bit_cnt_i(bit_cnt), .load_i(load),
        .tx_data_i(tx_data), .rx_next_o(rx_next), .sdo_o(sdo_o)
    );

    rsp_regfile #(.DW(DW), .AW(AW)) u_bank (
        .clk(clk), .rst(rst), .we_i(we), .waddr_i(waddr),
        .wdata_i(wdata), .regs_o(regs_o)
    );

    assign sdo_en_o = !abort && (phase == PH_DATA) && rd;

    // R3: the drive only switches on right after a captured command bit
    p_oe_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (!csn_i && !$past(csn_i) && $rose(sdo_en_o)) |-> $past(rise));

endmodule

// File: tb/tb_rsp_port.sv
module tb_rsp_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NREG       = 32;

    typedef struct packed {
        logic [7:0]  ins;
        logic [31:0] dat;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VT [NVEC] = '{
        '{8'h65, 32'h11223344, 32'h11223344},
        '{8'hE5, 32'h00000000, 32'h11223344},
        '{8'h1F, 32'hAA000000, 32'hAA000000},
        '{8'hC1, 32'h00000000, 32'hA1000000},
        '{8'h9F, 32'h00000000, 32'hAA000000},
        '{8'h22, 32'h77880000, 32'h77880000},
        '{8'hA2, 32'h00000000, 32'h77880000}
    };

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csn = 1'b1, prst = 1'b0, sdi = 1'b0;
    logic sdo, sdo_en;
    logic [NREG*8-1:0] regs;
    int   n_run = 0, n_fail = 0, r2_bad = 0;
    bit   done = 1'b0;
    logic [7:0] rx;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsp_port dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .prst_i(prst),
        .sdi_i(sdi), .sdo_o(sdo), .sdo_en_o(sdo_en), .regs_o(regs)
    );

    function automatic logic [7:0] rg(input int a);
        return regs[a*8 +: 8];
    endfunction

    function automatic logic [7:0] dflt(input int a);
        return (a == 0) ? 8'h00 : (8'hA0 + 8'(a));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        sdi = b;
        wt(HALF);
        r = sdo;
        sclk = 1'b1;
        wt(HALF);
        if (sdo !== r) r2_bad++;
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, input bit lsb, output logic [7:0] got);
        for (int i = 0; i < 8; i++) begin
            int   idx;
            logic r;
            idx = lsb ? i : 7 - i;
            bit_io(tx[idx], r);
            got[idx] = r;
        end
    endtask

    task automatic cs_on();
        csn = 1'b0;
        wt(HALF);
    endtask

    task automatic cs_off();
        wt(HALF);
        csn = 1'b1;
        wt(2*HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wt(3);
        rst = 1'b0;
        wt(2);

        // R12: reset values and drive off
        begin
            int bad = 0;
            for (int a = 0; a < NREG; a++) if (rg(a) !== dflt(a)) bad++;
            chk("R12 reset defaults", bad, 0);
        end
        chk("R12 R3 drive off after reset", sdo_en, 1'b0);

        // R1 R4 R11: table of MSB-first exchanges
        for (int v = 0; v < NVEC; v++) begin
            int n, a;
            logic [7:0] got [4];
            n = int'(VT[v].ins[6:5]) + 1;
            a = int'(VT[v].ins[4:0]);
            cs_on();
            xfer(VT[v].ins, 1'b0, rx);
            chk("R3 drive during data phase", sdo_en, VT[v].ins[7]);
            for (int j = 0; j < n; j++) xfer(VT[v].dat[31-8*j -: 8], 1'b0, got[j]);
            cs_off();
            chk("R3 drive off after select", sdo_en, 1'b0);
            for (int j = 0; j < n; j++) begin
                int aj;
                aj = (a - j < 0) ? 0 : a - j;
                if (VT[v].ins[7]) chk("R1 R4 R11 read byte", got[j], VT[v].exp[31-8*j -: 8]);
                else              chk("R1 R4 write byte", rg(aj), VT[v].exp[31-8*j -: 8]);
            end
        end

        // R8: software reset in the same byte as a register 0 update
        cs_on(); xfer(8'h00, 1'b0, rx); xfer(8'hA0, 1'b0, rx); cs_off();
        chk("R8 reg0 keeps bit7, bit5 clear", rg(0), 8'h80);
        chk("R8 reg5 restored", rg(5), dflt(5));
        chk("R8 reg2 restored", rg(2), dflt(2));
        chk("R8 reg31 restored", rg(31), dflt(31));

        // R6: order switched by the first data byte governs the second
        cs_on(); xfer(8'h20, 1'b0, rx); xfer(8'h40, 1'b0, rx); xfer(8'h5A, 1'b1, rx); cs_off();
        chk("R6 reg0 now LSB first", rg(0), 8'h40);
        chk("R6 second byte stepped up to reg1", rg(1), 8'h5A);

        // R5 R11: LSB-first write runs up into the top register
        cs_on(); xfer(8'h7D, 1'b1, rx);
        xfer(8'h01, 1'b1, rx); xfer(8'h02, 1'b1, rx); xfer(8'h03, 1'b1, rx); xfer(8'h04, 1'b1, rx);
        cs_off();
        chk("R5 reg1D", rg(29), 8'h01);
        chk("R5 reg1E", rg(30), 8'h02);
        chk("R11 reg1F holds last byte", rg(31), 8'h04);
        begin
            logic [7:0] g0, g1, g2, g3;
            cs_on(); xfer(8'hFD, 1'b1, rx);
            chk("R3 drive on LSB read", sdo_en, 1'b1);
            xfer(8'h00, 1'b1, g0); xfer(8'h00, 1'b1, g1); xfer(8'h00, 1'b1, g2); xfer(8'h00, 1'b1, g3);
            cs_off();
            chk("R5 R2 LSB read", {g0, g1, g2, g3}, 32'h01020404);
        end
        cs_on(); xfer(8'h00, 1'b1, rx); xfer(8'h00, 1'b1, rx); cs_off();
        chk("R5 back to MSB first", rg(0), 8'h00);

        // R9: port reset mid data byte, select held low
        cs_on(); xfer(8'h07, 1'b0, rx);
        for (int i = 0; i < 4; i++) begin
            logic r;
            bit_io(1'b1, r);
        end
        prst = 1'b1; wt(HALF); prst = 1'b0; wt(HALF);
        xfer(8'h08, 1'b0, rx); xfer(8'h3C, 1'b0, rx); cs_off();
        chk("R9 partial byte discarded", rg(7), dflt(7));
        chk("R9 fresh command after pulse", rg(8), 8'h3C);

        // R10: select raised mid byte
        cs_on(); xfer(8'h09, 1'b0, rx);
        for (int i = 0; i < 5; i++) begin
            logic r;
            bit_io(1'b0, r);
        end
        cs_off();
        chk("R10 abandoned byte", rg(9), dflt(9));
        cs_on(); xfer(8'h09, 1'b0, rx); xfer(8'h5D, 1'b0, rx); cs_off();
        chk("R10 new command after select", rg(9), 8'h5D);

        // R7: update at last bit, extra bytes ignored
        cs_on(); xfer(8'h0A, 1'b0, rx); xfer(8'hCC, 1'b0, rx);
        chk("R7 written before select rises", rg(10), 8'hCC);
        xfer(8'hDD, 1'b0, rx); cs_off();
        chk("R7 reg10 unchanged by extra byte", rg(10), 8'hCC);
        chk("R7 reg9 untouched", rg(9), 8'h5D);
        chk("R7 reg11 untouched", rg(11), dflt(11));

        chk("R2 output stable while clock high", r2_bad, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule